// File: doc/BRIEF.md
# FPU Last-Opcode Capture Register

This block records a compressed copy of the opcode of each floating-point instruction as it retires. Exception handlers and state-save sequences read it back. Every floating-point first opcode byte begins with the same five-bit prefix, so the block drops that prefix. It keeps the remaining three bits of the first byte together with the whole second byte, which gives an 11-bit value.

A mode input selects the update policy. In compatibility mode, every retiring non-control instruction overwrites the held value. With the mode off, the value changes only when the retiring instruction raises at least one exception that the control-word mask does not suppress. This saves update activity on the common path. A save request returns the held value one cycle later. A retire strobe that carries a first byte outside the floating-point range is dropped and reported on a one-cycle flag.

Top module: `fpu_lastop_capture`

## Requirements
- R1: While rst_ni is low, the held value is cleared to 0. A save request made after reset returns 0.
- R2: The held value is 11 bits wide. Bits [10:8] are bits [2:0] of the first opcode byte, and bits [7:0] are the second opcode byte.
- R3: When compat_mode_i is 1, every retire strobe with a legal first byte and ctrl_insn_i=0 loads the packed opcode at that clock edge.
- R4: When compat_mode_i is 0, a legal non-control retire loads the opcode only if (exc_flags_i & ~exc_mask_i) is nonzero. The bit order in both vectors is 0 invalid, 1 denormal, 2 divide-by-zero, 3 overflow, 4 underflow, 5 precision. A mask bit of 1 suppresses that exception.
- R5: A retire with ctrl_insn_i=1 never changes the held value, in either mode.
- R6: A retire whose first byte has top five bits other than 11011 (that is, outside 0xD8..0xDF) leaves the held value unchanged. It also drives illegal_o high for exactly the next cycle. A legal retire leaves illegal_o low.
- R7: A save request drives save_valid_o high in the next cycle. In that cycle save_fop_o shows the value held before the edge that sampled the request, even when a retire updates the value at that same edge.
- R8: Changing compat_mode_i does not alter the held value. The new policy applies to the next retire strobe.
- R9: save_fop_o does not change in any cycle that follows a cycle with no save request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | A floating-point instruction retires this cycle |
| op_byte0_i | input | 8 | First opcode byte |
| op_byte1_i | input | 8 | Second opcode byte |
| ctrl_insn_i | input | 1 | The retiring instruction is a control instruction |
| exc_flags_i | input | 6 | Exceptions raised by the retiring instruction |
| exc_mask_i | input | 6 | Control-word mask bits, 1 = masked |
| compat_mode_i | input | 1 | 1 = update on every non-control instruction |
| save_req_i | input | 1 | State-save request |
| save_valid_o | output | 1 | save_fop_o carries a fresh saved value |
| save_fop_o | output | 11 | Saved opcode value |
| illegal_o | output | 1 | The previous strobe carried a non-floating-point first byte |

## Verification
The held register can be seen only through a save. A wrong internal value therefore stays hidden until the next save request, and it appears one cycle after that request as a wrong save_fop_o. To expose lost or spurious updates, the bench places a save after every retire scenario. It uses distinct opcode values, so that a stale value cannot pass for a fresh one. A save issued at the same edge as an update catches ordering faults in that single cycle. A bad prefix decode shows up on illegal_o in the very next cycle.

// File: rtl/fop_pkg.sv
package fop_pkg;
  localparam int OP_W  = 8;
  localparam int PFX_W = 5;
  localparam int EXC_W = 6;
  localparam int FOP_W = 2 * OP_W - PFX_W;
  localparam logic [PFX_W-1:0] FP_PREFIX = 5'b11011;

  // exception flag bit positions
  typedef enum int {
    EXC_INVALID = 0,
    EXC_DENORM  = 1,
    EXC_ZDIV    = 2,
    EXC_OVFL    = 3,
    EXC_UNFL    = 4,
    EXC_PREC    = 5
  } exc_idx_e;
endpackage

// File: rtl/fop_pack.sv
module fop_pack #(
  parameter int OP_W  = fop_pkg::OP_W,
  parameter int PFX_W = fop_pkg::PFX_W,
  parameter logic [PFX_W-1:0] PREFIX = fop_pkg::FP_PREFIX,
  localparam int FOP_W = 2 * OP_W - PFX_W
) (
  input  logic [OP_W-1:0]  byte0_i,
  input  logic [OP_W-1:0]  byte1_i,
  output logic             legal_o,
  output logic [FOP_W-1:0] fop_o
);
  assign legal_o = (byte0_i[OP_W-1 -: PFX_W] == PREFIX);
  assign fop_o   = {byte0_i[OP_W-PFX_W-1:0], byte1_i};
endmodule

// File: rtl/fop_excp_qual.sv
module fop_excp_qual #(
  parameter int EXC_W = fop_pkg::EXC_W
) (
  input  logic [EXC_W-1:0] flags_i,
  input  logic [EXC_W-1:0] mask_i,
  output logic             unmasked_o
);
  logic [EXC_W-1:0] live;

  for (genvar g = 0; g < EXC_W; g++) begin : g_bit
    assign live[g] = flags_i[g] & ~mask_i[g];
  end

  assign unmasked_o = |live;
endmodule

// File: rtl/fop_hold_reg.sv
module fop_hold_reg #(
  parameter int W = fop_pkg::FOP_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         upd_i,
  input  logic [W-1:0] fop_i,
  input  logic         save_i,
  output logic [W-1:0] held_o,
  output logic         save_valid_o,
  output logic [W-1:0] save_fop_o
);
  logic [W-1:0] held_q;
  logic [W-1:0] save_q;
  logic         valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= '0;
      save_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (upd_i)  held_q <= fop_i;
      if (save_i) save_q <= held_q;  // pre-update value on collision
      valid_q <= save_i;
    end
  end

  assign held_o       = held_q;
  assign save_valid_o = valid_q;
  assign save_fop_o   = save_q;

  p_hold_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(held_o));
  p_save_old_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_i |=> (save_valid_o && save_fop_o == $past(held_o)));
  p_save_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !save_i |=> (!save_valid_o && $stable(save_fop_o)));
endmodule

// File: rtl/fpu_lastop_capture.sv
module fpu_lastop_capture #(
  parameter int OP_W  = fop_pkg::OP_W,
  parameter int PFX_W = fop_pkg::PFX_W,
  parameter int EXC_W = fop_pkg::EXC_W,
  parameter logic [PFX_W-1:0] PREFIX = fop_pkg::FP_PREFIX,
  localparam int FOP_W = 2 * OP_W - PFX_W,
  localparam int LOW_W = OP_W - PFX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  input  logic [OP_W-1:0]  op_byte0_i,
  input  logic [OP_W-1:0]  op_byte1_i,
  input  logic             ctrl_insn_i,
  input  logic [EXC_W-1:0] exc_flags_i,
  input  logic [EXC_W-1:0] exc_mask_i,
  input  logic             compat_mode_i,
  input  logic             save_req_i,
  output logic             save_valid_o,
  output logic [FOP_W-1:0] save_fop_o,
  output logic             illegal_o
);
  logic             legal;
  logic [FOP_W-1:0] packed_fop;
  logic             unmasked;
  logic             upd;
  logic [FOP_W-1:0] held;
  logic             illegal_q;

  fop_pack #(.OP_W(OP_W), .PFX_W(PFX_W), .PREFIX(PREFIX)) u_pack (
    .byte0_i (op_byte0_i),
    .byte1_i (op_byte1_i),
    .legal_o (legal),
    .fop_o   (packed_fop)
  );

  fop_excp_qual #(.EXC_W(EXC_W)) u_qual (
    .flags_i    (exc_flags_i),
    .mask_i     (exc_mask_i),
    .unmasked_o (unmasked)
  );

  assign upd = retire_i & legal & ~ctrl_insn_i & (compat_mode_i | unmasked);

  fop_hold_reg #(.W(FOP_W)) u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .upd_i        (upd),
    .fop_i        (packed_fop),
    .save_i       (save_req_i),
    .held_o       (held),
    .save_valid_o (save_valid_o),
    .save_fop_o   (save_fop_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_q <= 1'b0;
    else         illegal_q <= retire_i & ~legal;
  end
  assign illegal_o = illegal_q;

  p_pack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> (held[FOP_W-1 -: LOW_W] == $past(op_byte0_i[LOW_W-1:0])
             && held[OP_W-1:0] == $past(op_byte1_i)));
  p_compat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && compat_mode_i && !ctrl_insn_i
     && op_byte0_i[OP_W-1 -: PFX_W] == PREFIX) |=> held[OP_W-1:0] == $past(op_byte1_i));
  p_masked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!compat_mode_i && (exc_flags_i & ~exc_mask_i) == '0) |=> $stable(held));
  p_ctrl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && ctrl_insn_i) |=> $stable(held));
  p_illegal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && op_byte0_i[OP_W-1 -: PFX_W] != PREFIX) |=> (illegal_o && $stable(held)));
  p_no_illegal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_i |=> !illegal_o);
endmodule

// File: tb/fpu_lastop_capture_test.sv
`timescale 1ns/1ps
module fpu_lastop_capture_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        retire_i = 1'b0;
  logic [7:0]  op_byte0_i = '0;
  logic [7:0]  op_byte1_i = '0;
  logic        ctrl_insn_i = 1'b0;
  logic [5:0]  exc_flags_i = '0;
  logic [5:0]  exc_mask_i = '0;
  logic        compat_mode_i = 1'b1;
  logic        save_req_i = 1'b0;
  logic        save_valid_o;
  logic [10:0] save_fop_o;
  logic        illegal_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  fpu_lastop_capture uut (
    .clk_i, .rst_ni, .retire_i, .op_byte0_i, .op_byte1_i, .ctrl_insn_i,
    .exc_flags_i, .exc_mask_i, .compat_mode_i, .save_req_i,
    .save_valid_o, .save_fop_o, .illegal_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one retire strobe; illegal_o checked in the following cycle
  task automatic retire(input logic [7:0] b0, input logic [7:0] b1, input bit ctrl,
                        input logic [5:0] fl, input logic [5:0] mk, input bit exp_ill);
    @(negedge clk_i);
    retire_i = 1'b1; op_byte0_i = b0; op_byte1_i = b1;
    ctrl_insn_i = ctrl; exc_flags_i = fl; exc_mask_i = mk;
    @(negedge clk_i);
    retire_i = 1'b0; ctrl_insn_i = 1'b0; exc_flags_i = '0;
    check(illegal_o == exp_ill, "R6 illegal flag", illegal_o, exp_ill);
  endtask

  task automatic save_expect(input logic [10:0] exp, input string req);
    @(negedge clk_i);
    save_req_i = 1'b1;
    @(negedge clk_i);
    save_req_i = 1'b0;
    check(save_valid_o == 1'b1, "R7 save valid", save_valid_o, 1);
    check(save_fop_o == exp, req, save_fop_o, exp);
  endtask

  task automatic t_reset;
    check(save_valid_o == 1'b0 && illegal_o == 1'b0, "R1 outputs idle in reset",
          {save_valid_o, illegal_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    save_expect(11'h000, "R1 held value after reset");
  endtask

  task automatic t_compat_pack;
    compat_mode_i = 1'b1;
    retire(8'hD9, 8'hE8, 1'b0, 6'h00, 6'h3F, 1'b0);
    save_expect(11'h1E8, "R2 R3 pack D9 E8");
    retire(8'hDF, 8'h35, 1'b0, 6'h00, 6'h3F, 1'b0);
    save_expect(11'h735, "R2 R3 pack DF 35");
    retire(8'hD8, 8'h00, 1'b0, 6'h01, 6'h3F, 1'b0);
    save_expect(11'h000, "R3 masked exc still updates in compat");
    retire(8'hDF, 8'h35, 1'b0, 6'h00, 6'h3F, 1'b0);
  endtask

  task automatic t_ctrl;
    compat_mode_i = 1'b1;
    retire(8'hDB, 8'h12, 1'b1, 6'h00, 6'h3F, 1'b0);
    save_expect(11'h735, "R5 control ignored compat");
    compat_mode_i = 1'b0;
    retire(8'hDB, 8'h12, 1'b1, 6'h3F, 6'h00, 1'b0);
    save_expect(11'h735, "R5 control ignored with unmasked exc");
  endtask

  task automatic t_masked;
    compat_mode_i = 1'b0;
    retire(8'hDA, 8'h55, 1'b0, 6'b000100, 6'b000100, 1'b0);
    save_expect(11'h735, "R4 masked zdiv no update");
    retire(8'hDA, 8'h55, 1'b0, 6'b000000, 6'b000000, 1'b0);
    save_expect(11'h735, "R4 no exception no update");
    retire(8'hDA, 8'h55, 1'b0, 6'b000100, 6'b111011, 1'b0);
    save_expect(11'h255, "R4 unmasked zdiv updates");
    retire(8'hDC, 8'h01, 1'b0, 6'b100000, 6'b011111, 1'b0);
    save_expect(11'h401, "R4 unmasked precision updates");
  endtask

  task automatic t_illegal;
    compat_mode_i = 1'b1;
    retire(8'hC8, 8'h77, 1'b0, 6'h00, 6'h3F, 1'b1);
    save_expect(11'h401, "R6 bad prefix no update");
    retire(8'hE0, 8'h77, 1'b0, 6'h00, 6'h3F, 1'b1);
    @(negedge clk_i);
    check(illegal_o == 1'b0, "R6 illegal one cycle only", illegal_o, 0);
    save_expect(11'h401, "R6 bad prefix E0 no update");
  endtask

  task automatic t_mode;
    @(negedge clk_i); compat_mode_i = 1'b0;
    @(negedge clk_i); compat_mode_i = 1'b1;
    @(negedge clk_i); compat_mode_i = 1'b0;
    save_expect(11'h401, "R8 mode toggle keeps value");
    retire(8'hDE, 8'hC9, 1'b0, 6'h00, 6'h3F, 1'b0);
    save_expect(11'h401, "R8 off-mode policy applied");
    compat_mode_i = 1'b1;
    retire(8'hDE, 8'hC9, 1'b0, 6'h00, 6'h3F, 1'b0);
    save_expect(11'h6C9, "R8 compat policy applied next strobe");
  endtask

  task automatic t_collision;
    compat_mode_i = 1'b1;
    @(negedge clk_i);
    retire_i = 1'b1; op_byte0_i = 8'hDD; op_byte1_i = 8'hAA; save_req_i = 1'b1;
    @(negedge clk_i);
    retire_i = 1'b0; save_req_i = 1'b0;
    check(save_valid_o == 1'b1, "R7 collision valid", save_valid_o, 1);
    check(save_fop_o == 11'h6C9, "R7 collision returns old value", save_fop_o, 11'h6C9);
    save_expect(11'h5AA, "R7 update landed after collision");
  endtask

  task automatic t_save_stable;
    retire(8'hD8, 8'h3C, 1'b0, 6'h00, 6'h3F, 1'b0);
    @(negedge clk_i);
    check(save_fop_o == 11'h5AA, "R9 save output held", save_fop_o, 11'h5AA);
    check(save_valid_o == 1'b0, "R9 valid low without request", save_valid_o, 0);
    save_expect(11'h03C, "R9 next save shows update");
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    t_compat_pack();
    t_ctrl();
    t_masked();
    t_illegal();
    t_mode();
    t_collision();
    t_save_stable();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule